// File: doc/BRIEF.md
# Linked-List Command Chain Walker

This block follows a chain of command nodes stored in a word-organised memory and streams the payload of each node to a downstream consumer. Every node opens with one header word that carries the number of payload words that follow it and the byte address of the next node. The walker reads the header, forwards the payload words in address order on a valid/ready output stream, adds one plus the payload length to a running word total, and moves to the next node. The total tells the caller how many memory words the chain occupied, so no second pass over the list is needed.

A walk ends at the reserved end-of-list address, after a node that links to itself, when a small three-entry address history shows the chain is revisiting a node, or when the number of visited nodes passes a hard cap. A one-cycle done pulse presents the final total together with a code naming why the walk ended. Two ready flags and a two-bit direction field form the status the block drives. The walk clears the ready flags while it runs. At the end it sets them again and zeroes the direction field.

The memory is an internal model of `2**RAM_AW` words with a simple write port for loading. Node addresses use the full 21-bit byte space, and the model keeps only the low word-index bits. On the payload stream, `out_data` is valid while `out_valid` is high. A word is taken on a rising edge where both `out_valid` and `out_ready` are high. While `out_ready` is low the word and its valid stay unchanged. The consumer may hold `out_ready` low for as long as it needs, and the walk simply stalls.

Top module: `chain_walker`

## Requirements
- R1: A header word holds the payload length in bits 31:24 and the next node's byte address in bits 20:0; the node's word index is its byte address divided by 4, and its payload words are read from the word indices directly after the header, in increasing order.
- R2: The start address is taken from bits 20:0 of `start_addr`; byte address 0x1FFFFF marks the end of the list, so a walk that reaches it, or starts on it, ends with end code 0 without reading a node.
- R3: A node whose next address equals its own address is fully processed, and the walk then ends with end code 1.
- R4: The walker remembers the last node address, one lower-side address and one higher-side address; a node equal to the lower-side or higher-side entry aborts the walk with end code 2 without being processed; otherwise the node becomes the lower-side entry if it is below the last address and the higher-side entry if not, and then becomes the last address.
- R5: At most MAX_NODES+1 nodes are processed; an attempt to visit one more node aborts with end code 3, and a chain of exactly MAX_NODES+1 nodes followed by the end address ends normally with code 0.
- R6: `word_total` equals the sum of 1 plus the payload length over all processed nodes; nodes rejected by loop or limit checks add nothing.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` stays unchanged on the next cycle; each payload word is delivered exactly once.
- R8: Starting a walk clears `sts_cmd_rdy` and `sts_dma_rdy`; ending it sets both and clears `sts_dir`; a `dir_wr` pulse loads `dir_val` into `sts_dir`.
- R9: `done` is high for exactly one cycle per walk, with `word_total` and `end_code` valid in that cycle; `busy` is high from the cycle after `start` until `done`, and `out_valid` is low whenever `busy` is low.
- R10: A `start` pulse that arrives while a walk is running is ignored.
- R11: After reset `busy`, `done` and `out_valid` are low, both ready flags are high and `sts_dir` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begins a walk when idle |
| start_addr | input | 32 | Byte address of the first node; bits 20:0 used |
| ld_we | input | 1 | Memory model write enable |
| ld_addr | input | RAM_AW | Memory model word index for writes |
| ld_data | input | 32 | Memory model write data |
| dir_wr | input | 1 | Loads `dir_val` into the direction field |
| dir_val | input | 2 | New direction field value |
| out_valid | output | 1 | Payload word available |
| out_ready | input | 1 | Consumer accepts the payload word |
| out_data | output | 32 | Payload word |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle end-of-walk pulse |
| word_total | output | 32 | Words read by the last walk |
| end_code | output | 2 | 0 end address, 1 self-link, 2 loop, 3 node cap |
| sts_cmd_rdy | output | 1 | Command-ready status flag |
| sts_dma_rdy | output | 1 | Transfer-ready status flag |
| sts_dir | output | 2 | Direction status field |

## Verification
Each node costs one decision cycle and one header cycle. Each payload word appears on the stream one cycle after its read is issued, and the next read follows the cycle after acceptance. `done`, the total, the end code and the restored status all change on the edge after the final decision. The bench therefore never counts cycles for results. It waits, sampling on falling edges, until `done` is seen and then compares all end-of-walk values in that same half-cycle. The payload stream is compared word by word against an expected queue at every falling edge where valid and ready are both high, so the back-pressure pattern cannot shift the expected sequence.

// File: rtl/chain_walker_pkg.sv
package chain_walker_pkg;
  localparam int ADDR_BITS = 21;
  localparam int WIDX_BITS = ADDR_BITS - 2;
  localparam logic [ADDR_BITS-1:0] LIST_END = 21'h1FFFFF;
  localparam int LEN_LSB = 24;
  localparam int LEN_BITS = 8;

  typedef enum logic [1:0] {
    END_TERM  = 2'd0,
    END_SELF  = 2'd1,
    END_LOOP  = 2'd2,
    END_LIMIT = 2'd3
  } end_code_t;

  typedef enum logic [2:0] {
    S_IDLE, S_CHECK, S_HDR, S_PREQ, S_PDAT, S_NEXT
  } walk_state_t;
endpackage

// File: rtl/walk_ram.sv
module walk_ram #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [31:0]   wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [31:0]   rdata
);
  localparam int DEPTH = 1 << AW;
  logic [31:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/loop_guard.sv
module loop_guard #(
  parameter int W = 19
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         record,
  input  logic [W-1:0] probe,
  output logic         hit
);
  logic [W-1:0] last_q, low_q, high_q;
  logic         low_v, high_v;

  assign hit = (low_v && probe == low_q) || (high_v && probe == high_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q <= '1;
      low_q  <= '0;
      high_q <= '0;
      low_v  <= 1'b0;
      high_v <= 1'b0;
    end else if (clear) begin
      last_q <= '1;
      low_v  <= 1'b0;
      high_v <= 1'b0;
    end else if (record) begin
      if (probe < last_q) begin
        low_q <= probe;
        low_v <= 1'b1;
      end else begin
        high_q <= probe;
        high_v <= 1'b1;
      end
      last_q <= probe;
    end
  end
endmodule

// File: rtl/walk_status.sv
module walk_status (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       walk_begin,
  input  logic       walk_end,
  input  logic       dir_wr,
  input  logic [1:0] dir_val,
  output logic       cmd_rdy,
  output logic       dma_rdy,
  output logic [1:0] dir
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_rdy <= 1'b1;
      dma_rdy <= 1'b1;
      dir     <= 2'd0;
    end else begin
      if (dir_wr) dir <= dir_val;
      if (walk_begin) begin
        cmd_rdy <= 1'b0;
        dma_rdy <= 1'b0;
      end
      if (walk_end) begin
        cmd_rdy <= 1'b1;
        dma_rdy <= 1'b1;
        dir     <= 2'd0;
      end
    end
  end
endmodule

// File: rtl/chain_walker.sv
module chain_walker
  import chain_walker_pkg::*;
#(
  parameter int RAM_AW    = 8,
  parameter int MAX_NODES = 2000000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [31:0]       start_addr,
  input  logic              ld_we,
  input  logic [RAM_AW-1:0] ld_addr,
  input  logic [31:0]       ld_data,
  input  logic              dir_wr,
  input  logic [1:0]        dir_val,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [31:0]       out_data,
  output logic              busy,
  output logic              done,
  output logic [31:0]       word_total,
  output logic [1:0]        end_code,
  output logic              sts_cmd_rdy,
  output logic              sts_dma_rdy,
  output logic [1:0]        sts_dir
);
  localparam int NODE_W = $clog2(MAX_NODES + 2);
  localparam logic [NODE_W-1:0] NODE_CAP = NODE_W'(MAX_NODES);

  walk_state_t            st_q;
  logic [ADDR_BITS-1:0]   cur_q, next_q;
  logic [NODE_W-1:0]      nodes_q;
  logic [31:0]            acc_q, total_q;
  logic [LEN_BITS-1:0]    remain_q;
  logic [RAM_AW-1:0]      ptr_q;
  end_code_t              code_q, fin_code;
  logic                   done_q, busy_q, ovalid_q;

  logic                   rd_en;
  logic [RAM_AW-1:0]      rd_addr;
  logic [31:0]            rd_data;
  logic                   launch, at_end, over_cap, g_hit, g_record;
  logic                   fin_chk, fin_self, walk_end;
  logic [LEN_BITS-1:0]    hdr_len;
  logic [RAM_AW-1:0]      cur_idx;

  assign cur_idx = cur_q[RAM_AW+1:2];
  assign hdr_len = rd_data[LEN_LSB +: LEN_BITS];

  always_comb begin
    launch   = (st_q == S_IDLE) && start;
    at_end   = (cur_q == LIST_END);
    over_cap = (nodes_q > NODE_CAP);
    fin_chk  = (st_q == S_CHECK) && (at_end || over_cap || g_hit);
    g_record = (st_q == S_CHECK) && !fin_chk;
    fin_self = (st_q == S_NEXT) && (next_q == cur_q);
    walk_end = fin_chk || fin_self;
    if (st_q == S_NEXT)  fin_code = END_SELF;
    else if (at_end)     fin_code = END_TERM;
    else if (over_cap)   fin_code = END_LIMIT;
    else                 fin_code = END_LOOP;
    rd_en   = (st_q == S_CHECK) || (st_q == S_PREQ);
    rd_addr = (st_q == S_PREQ) ? ptr_q : cur_idx;
  end

  walk_ram #(.AW(RAM_AW)) u_ram (
    .clk   (clk),
    .we    (ld_we),
    .waddr (ld_addr),
    .wdata (ld_data),
    .re    (rd_en),
    .raddr (rd_addr),
    .rdata (rd_data)
  );

  loop_guard #(.W(WIDX_BITS)) u_guard (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (launch),
    .record (g_record),
    .probe  (cur_q[ADDR_BITS-1:2]),
    .hit    (g_hit)
  );

  walk_status u_status (
    .clk        (clk),
    .rst_n      (rst_n),
    .walk_begin (launch),
    .walk_end   (walk_end),
    .dir_wr     (dir_wr),
    .dir_val    (dir_val),
    .cmd_rdy    (sts_cmd_rdy),
    .dma_rdy    (sts_dma_rdy),
    .dir        (sts_dir)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= S_IDLE;
      cur_q    <= '0;
      next_q   <= '0;
      nodes_q  <= '0;
      acc_q    <= '0;
      total_q  <= '0;
      remain_q <= '0;
      ptr_q    <= '0;
      code_q   <= END_TERM;
      done_q   <= 1'b0;
      busy_q   <= 1'b0;
      ovalid_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st_q)
        S_IDLE: if (start) begin
          cur_q   <= start_addr[ADDR_BITS-1:0];
          acc_q   <= '0;
          nodes_q <= '0;
          busy_q  <= 1'b1;
          st_q    <= S_CHECK;
        end
        S_CHECK: begin
          nodes_q <= nodes_q + 1'b1;
          st_q    <= S_HDR;
        end
        S_HDR: begin
          next_q   <= rd_data[ADDR_BITS-1:0];
          acc_q    <= acc_q + 32'd1 + 32'(hdr_len);
          remain_q <= hdr_len;
          ptr_q    <= cur_idx + 1'b1;
          st_q     <= (hdr_len == '0) ? S_NEXT : S_PREQ;
        end
        S_PREQ: begin
          ovalid_q <= 1'b1;
          st_q     <= S_PDAT;
        end
        S_PDAT: if (out_ready) begin
          ovalid_q <= 1'b0;
          ptr_q    <= ptr_q + 1'b1;
          remain_q <= remain_q - 1'b1;
          st_q     <= (remain_q == LEN_BITS'(1)) ? S_NEXT : S_PREQ;
        end
        S_NEXT: begin
          cur_q <= next_q;
          st_q  <= S_CHECK;
        end
        default: st_q <= S_IDLE;
      endcase
      if (walk_end) begin
        st_q    <= S_IDLE;
        done_q  <= 1'b1;
        total_q <= acc_q;
        code_q  <= fin_code;
        busy_q  <= 1'b0;
      end
    end
  end

  assign out_valid  = ovalid_q;
  assign out_data   = rd_data;
  assign busy       = busy_q;
  assign done       = done_q;
  assign word_total = total_q;
  assign end_code   = code_q;
endmodule

// File: rtl/chain_walker_chk.sv
module chain_walker_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        done,
  input logic        out_valid,
  input logic        out_ready,
  input logic [31:0] out_data,
  input logic        sts_cmd_rdy,
  input logic        sts_dma_rdy,
  input logic [1:0]  sts_dir
);
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !out_valid);

  p_end_status_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (sts_cmd_rdy && sts_dma_rdy && sts_dir == 2'd0 && !busy));

  p_busy_status_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (!sts_cmd_rdy && !sts_dma_rdy));
endmodule

bind chain_walker chain_walker_chk u_chk (.*);

// File: tb/chain_walker_bench.sv
module chain_walker_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 6;
  localparam int CAP = 5;
  localparam int WORDS = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [31:0] start_addr = '0;
  logic ld_we = 1'b0;
  logic [AW-1:0] ld_addr = '0;
  logic [31:0] ld_data = '0;
  logic dir_wr = 1'b0;
  logic [1:0] dir_val = '0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic [31:0] out_data;
  logic busy, done;
  logic [31:0] word_total;
  logic [1:0] end_code;
  logic sts_cmd_rdy, sts_dma_rdy;
  logic [1:0] sts_dir;

  int n_checks = 0;
  int n_fail = 0;
  int cyc = 0;
  int rx_cnt = 0;
  int done_cnt = 0;
  bit bp_en = 1'b0;
  int bp_mod = 2;
  logic [31:0] exp_q [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  chain_walker #(.RAM_AW(AW), .MAX_NODES(CAP)) u_chain_walker (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
    .ld_we(ld_we), .ld_addr(ld_addr), .ld_data(ld_data),
    .dir_wr(dir_wr), .dir_val(dir_val),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .busy(busy), .done(done), .word_total(word_total), .end_code(end_code),
    .sts_cmd_rdy(sts_cmd_rdy), .sts_dma_rdy(sts_dma_rdy), .sts_dir(sts_dir)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] pat(input int w);
    return 32'hA000_0000 | 32'(w);
  endfunction

  function automatic logic [31:0] hdr(input int len, input logic [20:0] nxt);
    return {8'(len), 3'b000, nxt};
  endfunction

  always @(negedge clk) begin
    cyc++;
    out_ready = bp_en ? ((cyc % bp_mod) != 0) : 1'b1;
    if (out_valid && out_ready) begin
      rx_cnt++;
      if (exp_q.size() == 0) chk(1'b0, "R7 extra payload word", int'(out_data), 0);
      else begin
        logic [31:0] e;
        e = exp_q.pop_front();
        chk(out_data == e, "R1 payload word", int'(out_data), int'(e));
      end
    end
    if (done) done_cnt++;
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=<150000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  task automatic ld(input int w, input logic [31:0] d);
    ld_we = 1'b1; ld_addr = AW'(w); ld_data = d;
    @(negedge clk);
    ld_we = 1'b0;
  endtask

  task automatic fill();
    for (int i = 0; i < WORDS; i++) ld(i, pat(i));
  endtask

  task automatic expect_payload(input int first_w, input int len);
    for (int i = 0; i < len; i++) exp_q.push_back(pat(first_w + i));
  endtask

  task automatic walk(input logic [31:0] a, input int etot, input int ecode,
                      input int ewords, input bit restart, input string req);
    int t;
    rx_cnt = 0; done_cnt = 0; t = 0;
    start = 1'b1; start_addr = a;
    @(negedge clk);
    start = 1'b0;
    chk(busy && !sts_cmd_rdy && !sts_dma_rdy, "R8 status cleared during walk",
        {busy, sts_cmd_rdy, sts_dma_rdy}, 3'b100);
    if (restart) begin
      start = 1'b1; start_addr = 32'h0000_0080;
      @(negedge clk);
      start = 1'b0;
    end
    while (!done && t < 4000) begin @(negedge clk); t++; end
    chk(done == 1'b1, {req, " done seen"}, done, 1);
    chk(word_total == 32'(etot), {req, " R6 word total"}, int'(word_total), etot);
    chk(end_code == 2'(ecode), {req, " end code"}, end_code, ecode);
    chk(sts_cmd_rdy && sts_dma_rdy && sts_dir == 2'd0, "R8 status restored",
        {sts_cmd_rdy, sts_dma_rdy, sts_dir}, 4'b1100);
    repeat (3) @(negedge clk);
    chk(rx_cnt == ewords && exp_q.size() == 0, {req, " R7 payload count"}, rx_cnt, ewords);
    chk(done_cnt == 1, "R9 single done pulse", done_cnt, 1);
    chk(!busy, "R9 idle after done", busy, 0);
    exp_q.delete();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !out_valid, "R11 reset outputs low", {busy, done, out_valid}, 0);
    chk(sts_cmd_rdy && sts_dma_rdy && sts_dir == 2'd0, "R11 reset status",
        {sts_cmd_rdy, sts_dma_rdy, sts_dir}, 4'b1100);

    // R8: direction field load
    dir_val = 2'd2; dir_wr = 1'b1;
    @(negedge clk);
    dir_wr = 1'b0;
    @(negedge clk);
    chk(sts_dir == 2'd2, "R8 direction load", sts_dir, 2);

    // R1, R2, R6: three-node chain, start address with upper bits set (masked)
    fill();
    ld(4, hdr(2, 21'h20));  expect_payload(5, 2);
    ld(8, hdr(3, 21'h40));  expect_payload(9, 3);
    ld(16, hdr(1, 21'h1FFFFF)); expect_payload(17, 1);
    walk(32'hFFE0_0010, 9, 0, 6, 1'b0, "R1 R2 chain");

    // R10: second start during the walk ignored
    expect_payload(5, 2); expect_payload(9, 3); expect_payload(17, 1);
    walk(32'h0000_0010, 9, 0, 6, 1'b1, "R10 restart ignored");

    // R2: start on the end address
    walk(32'hABFF_FFFF, 0, 0, 0, 1'b0, "R2 start at end");

    // R3: self-link
    fill();
    ld(32, hdr(2, 21'h80)); expect_payload(33, 2);
    walk(32'h80, 3, 1, 2, 1'b0, "R3 self link");

    // R4: loop between two nodes
    fill();
    ld(24, hdr(1, 21'h90)); expect_payload(25, 1);
    ld(36, hdr(0, 21'h60));
    walk(32'h60, 3, 2, 1, 1'b0, "R4 loop");

    // R5: node cap exceeded (ascending chain of 8)
    fill();
    for (int k = 1; k <= 8; k++) ld(k, hdr(0, (k == 8) ? 21'h1FFFFF : 21'(4 * (k + 1))));
    walk(32'h4, CAP + 1, 3, 0, 1'b0, "R5 cap exceeded");

    // R5: exactly CAP+1 nodes then end
    fill();
    for (int k = 1; k <= CAP + 1; k++)
      ld(k, hdr(0, (k == CAP + 1) ? 21'h1FFFFF : 21'(4 * (k + 1))));
    walk(32'h4, CAP + 1, 0, 0, 1'b0, "R5 cap boundary");

    // R7 sweep: payload lengths 0..7 under varying back-pressure
    bp_en = 1'b1;
    for (int len = 0; len < 8; len++) begin
      fill();
      bp_mod = len + 2;
      ld(16, hdr(len, 21'h1FFFFF)); expect_payload(17, len);
      walk(32'h40, 1 + len, 0, len, 1'b0, "R7 back-pressure sweep");
    end
    bp_en = 1'b0;

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule